// File: doc/BRIEF.md
# Shared Multiply-Divide Exponent Pipeline

This block computes the result exponent for a floating-point multiplier and divider that share one exponent datapath. Each accepted operation carries two biased operand exponents with their sign bits and an operation select. In the first stage the exponents are combined: added for a multiply, with the bias taken out once, or subtracted for a divide, with the bias put back once. The operands are also screened for a zero divisor, for reserved-operand encodings and for zero operands.

One cycle after the operands, the fraction path supplies a normalize shift count. The second stage computes the candidate exponents for shifts of -1, 0 and +1 in parallel and picks one with the count. Only after that pick does it check the chosen value for overflow and underflow. Any exception raises a force signal, which tells the packing logic to write a reserved-operand pattern in place of a number. A valid bit travels through both stages, so every flag refers to a real operation.

Top module: `exp_muldiv_pipe`

## Requirements
- R1: A multiply with normal operands and shift code 00 yields exponent a_exp + b_exp - BIAS, where BIAS = 2^(EXP_W-1) (128 for EXP_W = 8).
- R2: A divide with normal operands and shift code 00 yields exponent a_exp - b_exp + BIAS (a is the dividend, b the divisor).
- R3: The 2-bit norm_shift is sampled one cycle after the operands. Code 01 adds 1 to the exponent, code 11 subtracts 1, and codes 00 and 10 leave it unchanged.
- R4: A result appears on the outputs exactly two clock cycles after in_valid is sampled high. Operations may be issued back to back, and each produces one out_valid cycle in issue order.
- R5: If the selected exponent exceeds 2^EXP_W - 1, exc_ovf is raised and force_rsv is raised. A selected value of exactly 2^EXP_W - 1 is not an overflow. While force_rsv is high, res_exp is 0.
- R6: If the selected exponent is below 1, exc_unf is raised and force_rsv is raised. The check uses the value after the shift, so a pre-shift value of 0 with code 01 is not an underflow.
- R7: A divide whose divisor has sign 0 and exponent 0 raises exc_dvz and force_rsv. A multiply by such an operand never raises exc_dvz.
- R8: An operand with sign 1 and exponent 0 is a reserved operand. Either operand in that form raises exc_rsv and force_rsv. exc_rsv takes priority over exc_dvz, exc_ovf and exc_unf, which stay low in that case.
- R9: A multiply with a zero operand, or a divide with a zero dividend and a non-zero divisor, gives res_exp 0 with no flags raised. In this case the computed exponent is ignored.
- R10: While out_valid is low, all four flags and force_rsv are 0. force_rsv equals the OR of the four flags.
- R11: After a synchronous active-low reset, out_valid and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle form an operation |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| a_sign | input | 1 | Sign bit of operand a (multiplicand or dividend) |
| a_exp | input | EXP_W | Biased exponent of operand a |
| b_sign | input | 1 | Sign bit of operand b (multiplier or divisor) |
| b_exp | input | EXP_W | Biased exponent of operand b |
| norm_shift | input | 2 | Normalize shift code for the operation issued one cycle earlier |
| out_valid | output | 1 | Result fields are valid |
| res_exp | output | EXP_W | Final biased exponent (0 on exception or zero result) |
| exc_ovf | output | 1 | Exponent overflow |
| exc_unf | output | 1 | Exponent underflow |
| exc_dvz | output | 1 | Divide by zero |
| exc_rsv | output | 1 | Reserved operand on input |
| force_rsv | output | 1 | Write a reserved-operand pattern to the destination |

## Verification
The bench works the range limits from both sides. It checks a selected exponent of exactly 255 against 256, and 1 against 0. It also checks that the range test comes after the shift: a pre-shift 0 with a +1 shift must not underflow, and a pre-shift 255 with a +1 shift must overflow. A design that tested the range before the shift would report those two cases the wrong way round. Priority cases also get direct stimulus:
- 0/0 must report divide by zero rather than a zero result.
- A reserved dividend over a zero divisor must report only the reserved operand.
- A zero multiplicand must hide an exponent that would otherwise underflow.

Mixed back-to-back traffic covers the shift code arriving one cycle after its operands. Mispairing the shift with a neighbouring operation, or dropping the reserved shift code into the wrong arm, shows up as an exponent off by one.

// File: rtl/expp_pkg.sv
// Shared definitions for the multiply/divide exponent pipeline.
// Assumes the normalize shift code is two bits wide with a two's-complement meaning.
package expp_pkg;

    // Normalize shift code; the unused pattern behaves as no shift.
    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_UP   = 2'b01,
        SH_RSVD = 2'b10,
        SH_DOWN = 2'b11
    } nshift_e;

    // Number of candidate exponents computed in parallel (-1, 0, +1).
    localparam int NUM_CAND = 3;

endpackage

// File: rtl/exp_front.sv
// First exponent stage: combines the two biased exponents (add for multiply,
// subtract for divide, keeping the result biased) and screens the operands
// for reserved encodings, a zero divisor and zero operands.
// Assumes EXP_W >= 3; the sum is carried with two guard bits as a signed value.
module exp_front #(
    parameter int EXP_W = 8,
    localparam int RW   = EXP_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 op_div,
    input  logic                 a_sign,
    input  logic [EXP_W-1:0]     a_exp,
    input  logic                 b_sign,
    input  logic [EXP_W-1:0]     b_exp,
    output logic                 s1_valid,
    output logic signed [RW-1:0] s1_raw,
    output logic                 s1_dvz,
    output logic                 s1_rsv,
    output logic                 s1_zero
);
    localparam int BIAS = 1 << (EXP_W - 1);
    localparam logic signed [RW-1:0] BIAS_S = RW'(BIAS);

    logic a_is_rsv, b_is_rsv, a_is_zero, b_is_zero;
    logic rsv_c, dvz_c, zero_c;
    logic signed [RW-1:0] ea, eb, raw_c;

    // Classify each operand from its sign and exponent.
    always_comb begin
        a_is_rsv  = a_sign  && (a_exp == '0);
        b_is_rsv  = b_sign  && (b_exp == '0);
        a_is_zero = !a_sign && (a_exp == '0);
        b_is_zero = !b_sign && (b_exp == '0);
    end

    // Resolve the exception and zero conditions in priority order.
    always_comb begin
        rsv_c  = a_is_rsv || b_is_rsv;
        dvz_c  = !rsv_c && op_div && b_is_zero;
        zero_c = !rsv_c && !dvz_c && (op_div ? a_is_zero : (a_is_zero || b_is_zero));
    end

    // Add or subtract the exponents and correct the bias once.
    always_comb begin
        ea = signed'({2'b00, a_exp});
        eb = signed'({2'b00, b_exp});
        if (op_div) raw_c = ea - eb + BIAS_S;
        else        raw_c = ea + eb - BIAS_S;
    end

    // Stage register; conditions are cleared for idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_raw   <= '0;
            s1_dvz   <= 1'b0;
            s1_rsv   <= 1'b0;
            s1_zero  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_raw   <= in_valid ? raw_c : '0;
            s1_dvz   <= in_valid && dvz_c;
            s1_rsv   <= in_valid && rsv_c;
            s1_zero  <= in_valid && zero_c;
        end
    end

    // R7
    dvz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_dvz |-> (!s1_rsv && !s1_zero));

    // R4
    front_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);

endmodule

// File: rtl/exp_norm_sel.sv
// Normalization select: builds the exponent candidates for shifts of
// -1, 0 and +1 in parallel and picks one with the shift code.
// Assumes the shift code arrives in the same cycle as the stage-1 result.
module exp_norm_sel
    import expp_pkg::*;
#(
    parameter int EXP_W = 8,
    localparam int RW   = EXP_W + 2
) (
    input  logic signed [RW-1:0] raw,
    input  logic [1:0]           shift_code,
    output logic signed [RW-1:0] sel_exp
);
    logic signed [RW-1:0] cand [NUM_CAND];
    logic [1:0] pick;

    // One adder per candidate; candidate i corresponds to shift i-1.
    for (genvar i = 0; i < NUM_CAND; i++) begin : g_cand
        localparam logic signed [RW-1:0] OFS = RW'(i) - RW'(1);
        assign cand[i] = raw + OFS;
    end

    // Decode the shift code into a candidate index.
    always_comb begin
        case (nshift_e'(shift_code))
            SH_UP:   pick = 2'd2;
            SH_DOWN: pick = 2'd0;
            default: pick = 2'd1;
        endcase
    end

    // Three-way select of the final exponent.
    always_comb begin
        case (pick)
            2'd0:    sel_exp = cand[0];
            2'd2:    sel_exp = cand[2];
            default: sel_exp = cand[1];
        endcase
    end

endmodule

// File: rtl/exp_range_chk.sv
// Range check on the selected exponent: above the largest biased code is
// overflow, below 1 is underflow.
// Assumes the input is the post-normalization exponent, carried signed.
module exp_range_chk #(
    parameter int EXP_W = 8,
    localparam int RW   = EXP_W + 2
) (
    input  logic signed [RW-1:0] sel_exp,
    output logic                 ovf_c,
    output logic                 unf_c
);
    localparam logic signed [RW-1:0] MAXE = RW'((1 << EXP_W) - 1);
    localparam logic signed [RW-1:0] MINE = RW'(1);

    // Compare against both ends of the representable range.
    always_comb begin
        ovf_c = sel_exp > MAXE;
        unf_c = sel_exp < MINE;
    end

endmodule

// File: rtl/exp_muldiv_pipe.sv
// Top of the shared exponent pipeline. Stage 1 combines the exponents and
// screens the operands. Stage 2 takes the shift code, selects the final
// exponent, range-checks it, and registers the result and exception flags.
// Assumes norm_shift belongs to the operation issued one cycle earlier.
module exp_muldiv_pipe #(
    parameter int EXP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_div,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [1:0]       norm_shift,
    output logic             out_valid,
    output logic [EXP_W-1:0] res_exp,
    output logic             exc_ovf,
    output logic             exc_unf,
    output logic             exc_dvz,
    output logic             exc_rsv,
    output logic             force_rsv
);
    localparam int RW = EXP_W + 2;

    logic                 s1_valid, s1_dvz, s1_rsv, s1_zero;
    logic signed [RW-1:0] s1_raw, sel_exp;
    logic                 ovf_c, unf_c, range_ok, any_exc;

    exp_front #(.EXP_W(EXP_W)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op_div   (op_div),
        .a_sign   (a_sign),
        .a_exp    (a_exp),
        .b_sign   (b_sign),
        .b_exp    (b_exp),
        .s1_valid (s1_valid),
        .s1_raw   (s1_raw),
        .s1_dvz   (s1_dvz),
        .s1_rsv   (s1_rsv),
        .s1_zero  (s1_zero)
    );

    exp_norm_sel #(.EXP_W(EXP_W)) u_sel (
        .raw        (s1_raw),
        .shift_code (norm_shift),
        .sel_exp    (sel_exp)
    );

    exp_range_chk #(.EXP_W(EXP_W)) u_range (
        .sel_exp (sel_exp),
        .ovf_c   (ovf_c),
        .unf_c   (unf_c)
    );

    // Range flags count only for numeric results with no earlier exception.
    always_comb begin
        range_ok = !s1_rsv && !s1_dvz && !s1_zero;
        any_exc  = s1_rsv || s1_dvz || (range_ok && (ovf_c || unf_c));
    end

    // Output stage register; every field is cleared on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_exp   <= '0;
            exc_ovf   <= 1'b0;
            exc_unf   <= 1'b0;
            exc_dvz   <= 1'b0;
            exc_rsv   <= 1'b0;
            force_rsv <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            exc_rsv   <= s1_valid && s1_rsv;
            exc_dvz   <= s1_valid && s1_dvz;
            exc_ovf   <= s1_valid && range_ok && ovf_c;
            exc_unf   <= s1_valid && range_ok && unf_c;
            force_rsv <= s1_valid && any_exc;
            res_exp   <= (s1_valid && !any_exc && !s1_zero) ? sel_exp[EXP_W-1:0] : '0;
        end
    end

    // R4
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(exc_ovf || exc_unf || exc_dvz || exc_rsv || force_rsv));

    // R10
    force_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_rsv == (exc_ovf || exc_unf || exc_dvz || exc_rsv));

    // R5
    range_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_ovf && exc_unf));

    // R5
    forced_exp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_rsv |-> (res_exp == '0));

    // R8
    rsv_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_rsv |-> (!exc_dvz && !exc_ovf && !exc_unf));

    // R7
    dvz_no_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_dvz |-> (!exc_ovf && !exc_unf));

endmodule

// File: tb/test_exp_muldiv_pipe.sv
// Scoreboard bench: the driver pushes expected results into a queue and a
// monitor pops and compares them whenever out_valid is seen.
module test_exp_muldiv_pipe;
    localparam int EXP_W = 8;
    localparam int BIAS  = 128;
    localparam int MAXE  = 255;

    typedef struct {
        int          exp_v;
        bit          ovf, unf, dvz, rsv;
        int          issue_cyc;
        string       tag;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             op_div = 1'b0;
    logic             a_sign = 1'b0;
    logic [EXP_W-1:0] a_exp = '0;
    logic             b_sign = 1'b0;
    logic [EXP_W-1:0] b_exp = '0;
    logic [1:0]       norm_shift = 2'b00;
    logic             out_valid;
    logic [EXP_W-1:0] res_exp;
    logic             exc_ovf, exc_unf, exc_dvz, exc_rsv, force_rsv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    logic [1:0] shift_pend = 2'b00;
    exp_item_t sb[$];

    exp_muldiv_pipe #(.EXP_W(EXP_W)) i_exp_muldiv_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_div(op_div),
        .a_sign(a_sign), .a_exp(a_exp), .b_sign(b_sign), .b_exp(b_exp),
        .norm_shift(norm_shift), .out_valid(out_valid), .res_exp(res_exp),
        .exc_ovf(exc_ovf), .exc_unf(exc_unf), .exc_dvz(exc_dvz),
        .exc_rsv(exc_rsv), .force_rsv(force_rsv)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_item_t model(input bit dv, input bit as, input int ae,
                                        input bit bs, input int be, input logic [1:0] sh,
                                        input string tag);
        exp_item_t it;
        bit rsv, dvz, zro;
        int f;
        rsv = (as && ae == 0) || (bs && be == 0);
        dvz = !rsv && dv && !bs && be == 0;
        zro = !rsv && !dvz && (dv ? (!as && ae == 0) : ((!as && ae == 0) || (!bs && be == 0)));
        f = dv ? (ae - be + BIAS) : (ae + be - BIAS);
        f += (sh == 2'b01) ? 1 : (sh == 2'b11) ? -1 : 0;
        it.rsv = rsv;
        it.dvz = dvz;
        it.ovf = !rsv && !dvz && !zro && f > MAXE;
        it.unf = !rsv && !dvz && !zro && f < 1;
        it.exp_v = (rsv || dvz || zro || it.ovf || it.unf) ? 0 : f;
        it.tag = tag;
        it.issue_cyc = 0;
        return it;
    endfunction

    // Drive one operation; its shift code goes out on the following cycle.
    task automatic issue(input bit dv, input bit as, input int ae, input bit bs,
                         input int be, input logic [1:0] sh, input string tag);
        exp_item_t it;
        @(negedge clk);
        norm_shift = shift_pend;
        shift_pend = sh;
        in_valid = 1'b1;
        op_div = dv; a_sign = as; a_exp = ae[EXP_W-1:0];
        b_sign = bs; b_exp = be[EXP_W-1:0];
        it = model(dv, as, ae, bs, be, sh, tag);
        it.issue_cyc = cyc;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            norm_shift = shift_pend;
            shift_pend = 2'b00;
            in_valid = 1'b0;
            a_exp = 8'hA5; b_exp = 8'h5A;
        end
    endtask

    // Monitor: pop and compare on every valid output; check quiet flags otherwise.
    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected out_valid", 1, 0);
                end else begin
                    exp_item_t e;
                    e = sb.pop_front();
                    check(cyc - e.issue_cyc == 2, {e.tag, " R4 latency"}, cyc - e.issue_cyc, 2);
                    check(res_exp == e.exp_v[EXP_W-1:0], {e.tag, " res_exp"}, res_exp, e.exp_v);
                    check(exc_ovf == e.ovf, {e.tag, " R5 exc_ovf"}, exc_ovf, e.ovf);
                    check(exc_unf == e.unf, {e.tag, " R6 exc_unf"}, exc_unf, e.unf);
                    check(exc_dvz == e.dvz, {e.tag, " R7 exc_dvz"}, exc_dvz, e.dvz);
                    check(exc_rsv == e.rsv, {e.tag, " R8 exc_rsv"}, exc_rsv, e.rsv);
                    check(force_rsv == (e.ovf | e.unf | e.dvz | e.rsv), {e.tag, " R10 force_rsv"},
                          force_rsv, e.ovf | e.unf | e.dvz | e.rsv);
                end
            end else begin
                check(!(exc_ovf | exc_unf | exc_dvz | exc_rsv | force_rsv),
                      "R10 flags while idle", exc_ovf | exc_unf | exc_dvz | exc_rsv | force_rsv, 0);
            end
        end
    end

    bit done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check(!out_valid, "R11 out_valid after reset", out_valid, 0);
        check(!(exc_ovf | exc_unf | exc_dvz | exc_rsv | force_rsv), "R11 flags after reset",
              exc_ovf | exc_unf | exc_dvz | exc_rsv | force_rsv, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle(2);

        issue(0, 0, 130, 0, 140, 2'b00, "R1 mul basic");
        issue(0, 1, 128, 1, 128, 2'b01, "R3 mul up");
        issue(1, 0, 200, 0, 100, 2'b00, "R2 div basic");
        issue(1, 0, 100, 0, 100, 2'b11, "R3 div down");
        issue(0, 0, 150, 0, 140, 2'b10, "R3 code10 no shift");
        idle(3);
        issue(0, 0, 200, 0, 200, 2'b00, "R5 mul ovf");
        issue(0, 0, 255, 0, 128, 2'b00, "R5 at max");
        issue(0, 0, 255, 0, 128, 2'b01, "R5 max plus one");
        issue(1, 0, 255, 0, 1,   2'b00, "R5 div ovf");
        issue(0, 0, 1,   0, 1,   2'b00, "R6 mul unf");
        issue(0, 0, 1,   0, 128, 2'b00, "R6 at min");
        issue(0, 0, 1,   0, 128, 2'b11, "R6 min minus one");
        issue(0, 0, 1,   0, 127, 2'b01, "R6 zero then up");
        issue(1, 0, 1,   0, 255, 2'b00, "R6 div unf");
        idle(2);
        issue(1, 0, 150, 0, 0,   2'b00, "R7 div by zero");
        issue(0, 0, 150, 0, 0,   2'b00, "R7 mul zero no dvz");
        issue(1, 0, 0,   0, 0,   2'b00, "R7 zero over zero");
        issue(0, 1, 0,   0, 140, 2'b00, "R8 rsv a");
        issue(1, 0, 140, 1, 0,   2'b00, "R8 rsv divisor");
        issue(1, 1, 0,   0, 0,   2'b01, "R8 rsv over zero");
        issue(0, 0, 0,   0, 1,   2'b11, "R9 mul zero hides unf");
        issue(1, 0, 0,   0, 5,   2'b00, "R9 div zero dividend");
        issue(0, 1, 130, 0, 0,   2'b01, "R9 mul by zero b");
        idle(1);
        for (int i = 0; i < 24; i++) begin
            issue(i % 2, i[0], 60 + i * 8, i[1], 40 + i * 9, 2'(i), "R1 R2 R3 sweep");
            if (i % 5 == 0) idle(1);
        end
        idle(4);
        check(sb.size() == 0, "R4 all results returned", sb.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule